// File: doc/BRIEF.md
# Sub-Block Direct-Mapped Cache

A direct-mapped cache of 1 KB built from 32 lines of 32 bytes. Each line is cut into four 8-byte sub-blocks, and each sub-block has its own valid flag. A lookup hits only when the stored tag matches and the addressed sub-block is valid. A matching tag alone is not enough. On a miss the cache fetches exactly one 8-byte sub-block from memory, so refill traffic follows what the processor actually touches rather than whole lines.

The processor side moves 32-bit words with per-byte enables and a ready signal. The processor holds its request until ready is seen high; the rising clock edge where request and ready are both high completes the access. The memory side moves one 8-byte sub-block per request with a request/acknowledge pair. Stores are write-back and allocate on a miss: the fetched sub-block is merged with the store's enabled bytes before it enters the array. Each line keeps one dirty flag. A dirty line that is evicted writes its valid sub-blocks back to memory before the new sub-block is fetched.

Top module: `cache_subblk`

## Requirements
- R1: After reset every sub-block is invalid, ready and memory request are low, and the first access to any address misses.
- R2: A request whose tag matches and whose sub-block is valid is a hit. Ready is high in the same cycle the request is presented, read data is valid with it, and no memory request is made.
- R3: When the tag matches but the addressed sub-block is invalid, exactly one memory read is issued. Its address is the 8-byte aligned address of the addressed sub-block. The other valid sub-blocks of the line stay valid and hit afterwards.
- R4: When the tag differs, the line takes the new tag, all of its valid flags are cleared, only the requested sub-block is fetched and made valid, and the other sub-blocks of the line miss afterwards.
- R5: A store that misses allocates its sub-block. Bytes whose enable is set take the store data, all other bytes keep the fetched memory data, and a later read returns the merged word.
- R6: A store that hits writes only the bytes whose enable bit is set (bit i covers data bits 8i+7:8i). It causes no memory traffic.
- R7: Replacing a dirty line writes back each valid sub-block of the old line and no invalid one. There is one 8-byte write per sub-block, at the address formed from the old tag, the index and the sub-block number, in ascending sub-block order. All write-backs come before the fill read.
- R8: Replacing a line that holds no store since its tag was set issues no memory write.
- R9: Ready stays low from a miss until its fill read has been acknowledged, and rises in the cycle after that acknowledge. Memory request, address and write flag hold steady until acknowledge, and memory addresses always have their three low bits at zero.
- R10: Address bits 4:0 select the byte in the line, with bits 4:3 selecting the sub-block and bit 2 the word inside it. Bits 9:5 select the line, and the bits above 9 are the tag. Bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReq | input | 1 | Processor access request, held until ready |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | ADDR_W | Byte address of the access |
| cpuBe | input | 4 | Byte enables for a store |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Load data, valid while ready is high |
| cpuReady | output | 1 | Access completes on this cycle's edge |
| memReq | output | 1 | Memory sub-block request |
| memWe | output | 1 | 1 = write-back, 0 = fill read |
| memAddr | output | ADDR_W | 8-byte aligned memory address |
| memWdata | output | 64 | Write-back sub-block data |
| memRdata | input | 64 | Fill sub-block data, valid with acknowledge |
| memAck | input | 1 | One-cycle completion of a memory request |

## Verification
The properties assume two things about the inputs. The processor keeps its request, address and store flag unchanged until it sees ready. The memory pulses acknowledge only while a request is pending. The fill-address and write-back checks compare the memory address against the processor address that is still held, so they depend on the first of these. The stimulus drives each access at a falling edge and releases it only after the edge on which ready was high, and the bench memory model raises acknowledge only for a pending request, for one cycle, after a latency of zero to two cycles.

// File: rtl/cache_pkg.sv
package cache_pkg;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic hitWrite;    // merge store word into a valid sub-block
    logic fillWrite;   // write the fetched sub-block and set its valid flag
    logic replaceTag;  // new tag: clear all valid flags, reset dirty
    logic setDirty;    // access is a store: merge bytes, mark line dirty
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_RESP  = 2'd3
  } ctrlState_t;

endpackage

// File: rtl/cache_datapath.sv
module cache_datapath
  import cache_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CACHE_BYTES = 1024,
  parameter int LINE_BYTES  = 32,
  parameter int SUB_BYTES   = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:2]       wordAddr,
  input  logic [3:0]              cpuBe,
  input  logic [31:0]             cpuWdata,
  input  dpStrobe_t               strobe,
  input  logic [$clog2(LINE_BYTES/SUB_BYTES)-1:0] wbSel,
  input  logic [SUB_BYTES*8-1:0]  memRdata,
  output logic [31:0]             cpuRdata,
  output logic                    hit,
  output logic                    tagMatch,
  output logic                    lineDirty,
  output logic [LINE_BYTES/SUB_BYTES-1:0] lineValid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(CACHE_BYTES/LINE_BYTES)-1:0] victimTag,
  output logic [SUB_BYTES*8-1:0]  victimData
);

  localparam int LINES    = CACHE_BYTES / LINE_BYTES;
  localparam int SUBS     = LINE_BYTES / SUB_BYTES;
  localparam int SUB_BITS = SUB_BYTES * 8;
  localparam int OFF_W    = $clog2(LINE_BYTES);
  localparam int IDX_W    = $clog2(LINES);
  localparam int SEL_W    = $clog2(SUBS);
  localparam int SOFF_W   = $clog2(SUB_BYTES);
  localparam int WSEL_W   = $clog2(SUB_BYTES / 4);
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
  localparam int ROWS     = LINES * SUBS;

  logic [IDX_W-1:0]  lineIdx;
  logic [TAG_W-1:0]  reqTag;
  logic [SEL_W-1:0]  subSel;
  logic [WSEL_W-1:0] wordSel;

  assign lineIdx = wordAddr[OFF_W +: IDX_W];
  assign reqTag  = wordAddr[ADDR_W-1 -: TAG_W];
  assign subSel  = wordAddr[SOFF_W +: SEL_W];
  assign wordSel = wordAddr[2 +: WSEL_W];

  logic [TAG_W-1:0]    tagArr   [LINES];
  logic [SUBS-1:0]     validArr [LINES];
  logic                dirtyArr [LINES];
  logic [SUB_BITS-1:0] dataArr  [ROWS];

  logic [SUB_BITS-1:0] curSub;
  logic [SUB_BITS-1:0] hitMerged;
  logic [SUB_BITS-1:0] fillMerged;
  logic [SUB_BITS-1:0] fillData;
  logic [SUBS-1:0]     subOneHot;

  assign curSub     = dataArr[{lineIdx, subSel}];
  assign victimData = dataArr[{lineIdx, wbSel}];
  assign victimTag  = tagArr[lineIdx];
  assign tagMatch   = (tagArr[lineIdx] == reqTag);
  assign lineValid  = validArr[lineIdx];
  assign lineDirty  = dirtyArr[lineIdx];
  assign hit        = tagMatch && validArr[lineIdx][subSel];
  assign cpuRdata   = curSub[int'(wordSel)*32 +: 32];
  assign subOneHot  = SUBS'(1) << subSel;

  // Byte-enable merge of the store word into a sub-block
  always_comb begin
    hitMerged  = curSub;
    fillMerged = memRdata;
    for (int b = 0; b < 4; b++) begin
      if (cpuBe[b]) begin
        hitMerged[(int'(wordSel)*4 + b)*8 +: 8]  = cpuWdata[b*8 +: 8];
        fillMerged[(int'(wordSel)*4 + b)*8 +: 8] = cpuWdata[b*8 +: 8];
      end
    end
  end

  assign fillData = strobe.setDirty ? fillMerged : memRdata;

  // Data array: no reset, contents guarded by the valid flags
  always_ff @(posedge clk) begin
    if (strobe.fillWrite) begin
      dataArr[{lineIdx, subSel}] <= fillData;
    end else if (strobe.hitWrite) begin
      dataArr[{lineIdx, subSel}] <= hitMerged;
    end
  end

  // Line state: tag, per-sub-block valid, dirty
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        tagArr[i]   <= '0;
        validArr[i] <= '0;
        dirtyArr[i] <= 1'b0;
      end
    end else if (strobe.fillWrite) begin
      tagArr[lineIdx] <= reqTag;
      if (strobe.replaceTag) begin
        validArr[lineIdx] <= subOneHot;
        dirtyArr[lineIdx] <= strobe.setDirty;
      end else begin
        validArr[lineIdx] <= validArr[lineIdx] | subOneHot;
        dirtyArr[lineIdx] <= dirtyArr[lineIdx] | strobe.setDirty;
      end
    end else if (strobe.hitWrite) begin
      dirtyArr[lineIdx] <= 1'b1;
    end
  end

endmodule

// File: rtl/cache_control.sv
module cache_control
  import cache_pkg::*;
#(
  parameter int SUBS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cpuReq,
  input  logic                     cpuWe,
  input  logic                     hit,
  input  logic                     tagMatch,
  input  logic                     lineDirty,
  input  logic [SUBS-1:0]          lineValid,
  input  logic                     memAck,
  output dpStrobe_t                strobe,
  output logic [$clog2(SUBS)-1:0]  wbSel,
  output logic                     cpuReady,
  output logic                     memReq,
  output logic                     memWe
);

  localparam int SEL_W = $clog2(SUBS);

  ctrlState_t      state, stateNext;
  logic [SUBS-1:0] wbMask, wbMaskNext;
  logic [SUBS-1:0] wbBit;

  // Lowest pending sub-block goes first
  always_comb begin
    wbSel = '0;
    for (int s = SUBS - 1; s >= 0; s--) begin
      if (wbMask[s]) wbSel = SEL_W'(s);
    end
  end

  assign wbBit = SUBS'(1) << wbSel;

  always_comb begin
    stateNext  = state;
    wbMaskNext = wbMask;
    strobe     = '0;
    cpuReady   = 1'b0;
    memReq     = 1'b0;
    memWe      = 1'b0;
    strobe.setDirty = cpuWe;
    unique case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          if (hit) begin
            cpuReady        = 1'b1;
            strobe.hitWrite = cpuWe;
          end else begin
            wbMaskNext = (!tagMatch && lineDirty) ? lineValid : '0;
            stateNext  = (wbMaskNext != '0) ? ST_WBACK : ST_FILL;
          end
        end
      end
      ST_WBACK: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          wbMaskNext = wbMask & ~wbBit;
          if (wbMaskNext == '0) stateNext = ST_FILL;
        end
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.fillWrite  = 1'b1;
          strobe.replaceTag = !tagMatch;
          stateNext         = ST_RESP;
        end
      end
      ST_RESP: begin
        cpuReady  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      wbMask <= '0;
    end else begin
      state  <= stateNext;
      wbMask <= wbMaskNext;
    end
  end

endmodule

// File: rtl/cache_subblk.sv
module cache_subblk
  import cache_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int CACHE_BYTES = 1024,
  parameter int LINE_BYTES  = 32,
  parameter int SUB_BYTES   = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cpuReq,
  input  logic                   cpuWe,
  input  logic [ADDR_W-1:0]      cpuAddr,
  input  logic [3:0]             cpuBe,
  input  logic [31:0]            cpuWdata,
  output logic [31:0]            cpuRdata,
  output logic                   cpuReady,
  output logic                   memReq,
  output logic                   memWe,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [SUB_BYTES*8-1:0] memWdata,
  input  logic [SUB_BYTES*8-1:0] memRdata,
  input  logic                   memAck
);

  localparam int LINES  = CACHE_BYTES / LINE_BYTES;
  localparam int SUBS   = LINE_BYTES / SUB_BYTES;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int SEL_W  = $clog2(SUBS);
  localparam int SOFF_W = $clog2(SUB_BYTES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

  dpStrobe_t        strobe;
  logic [SEL_W-1:0] wbSel;
  logic             hit, tagMatch, lineDirty;
  logic [SUBS-1:0]  lineValid;
  logic [TAG_W-1:0] victimTag;

  cache_datapath #(
    .ADDR_W(ADDR_W), .CACHE_BYTES(CACHE_BYTES),
    .LINE_BYTES(LINE_BYTES), .SUB_BYTES(SUB_BYTES)
  ) u_datapath (
    .clk(clk), .rstN(rstN),
    .wordAddr(cpuAddr[ADDR_W-1:2]), .cpuBe(cpuBe), .cpuWdata(cpuWdata),
    .strobe(strobe), .wbSel(wbSel), .memRdata(memRdata),
    .cpuRdata(cpuRdata), .hit(hit), .tagMatch(tagMatch),
    .lineDirty(lineDirty), .lineValid(lineValid),
    .victimTag(victimTag), .victimData(memWdata)
  );

  cache_control #(.SUBS(SUBS)) u_control (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe),
    .hit(hit), .tagMatch(tagMatch), .lineDirty(lineDirty),
    .lineValid(lineValid), .memAck(memAck),
    .strobe(strobe), .wbSel(wbSel), .cpuReady(cpuReady),
    .memReq(memReq), .memWe(memWe)
  );

  // Write-back uses the stored tag; fill uses the request address
  assign memAddr = memWe
    ? {victimTag, cpuAddr[OFF_W +: IDX_W], wbSel, {SOFF_W{1'b0}}}
    : {cpuAddr[ADDR_W-1:SOFF_W], {SOFF_W{1'b0}}};

endmodule

// File: rtl/cache_checker.sv
module cache_checker #(
  parameter int ADDR_W     = 16,
  parameter int OFF_W      = 5,
  parameter int IDX_W      = 5,
  parameter int SOFF_W     = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              cpuReady,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck
);

  localparam int TAG_LO = OFF_W + IDX_W;
  localparam int SEL_W  = OFF_W - SOFF_W;

  // R9: input assumption, processor holds a pending access
  p_cpu_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && !cpuReady |=> cpuReq && $stable(cpuAddr) && $stable(cpuWe));

  p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  p_mem_aligned_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[SOFF_W-1:0] == '0);

  p_no_ready_in_mem_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !cpuReady);

  p_ready_after_fill_r9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe && memAck |=> cpuReady);

  p_fill_own_sub_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe |-> memAddr[ADDR_W-1:SOFF_W] == cpuAddr[ADDR_W-1:SOFF_W]);

  p_wb_victim_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> memAddr[OFF_W +: IDX_W] == cpuAddr[OFF_W +: IDX_W]
                        && memAddr[ADDR_W-1:TAG_LO] != cpuAddr[ADDR_W-1:TAG_LO]);

  p_wb_ascending_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && $past(memReq && memWe && memAck)
      |-> memAddr[SOFF_W +: SEL_W] > $past(memAddr[SOFF_W +: SEL_W]));

endmodule

bind cache_subblk cache_checker #(
  .ADDR_W(ADDR_W), .OFF_W($clog2(LINE_BYTES)),
  .IDX_W($clog2(CACHE_BYTES / LINE_BYTES)), .SOFF_W($clog2(SUB_BYTES))
) u_checker (
  .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
  .cpuReady(cpuReady), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memAck(memAck)
);

// File: tb/test_cache_subblk.sv
module test_cache_subblk;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 12;
  localparam int WORDS = 1 << (AW - 2);
  localparam int SBLKS = 1 << (AW - 3);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [3:0] cpuBe = '0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic cpuReady, memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [63:0] memWdata;
  logic [63:0] memRdata = '0;
  logic memAck = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_subblk #(.ADDR_W(AW)) i_cache_subblk (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuBe(cpuBe), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference word image (program view) and backing memory
  logic [31:0] refw [WORDS];
  logic [63:0] mem  [SBLKS];
  // Requirement model of line state
  logic [1:0]  tagM   [32];
  logic [3:0]  validM [32];
  bit          dirtyM [32];

  // Expectations shared with the memory model
  logic [AW-1:0] expWbAddr [4];
  int            expWbN = 0;
  int            wbSeen = 0;
  logic [AW-1:0] expFillAddr = '0;
  int            rdCnt = 0, wrCnt = 0;
  bit            fillSeen = 0;
  int            lat = 0;
  int            waitCnt = 0;

  function automatic logic [31:0] initWord(int i);
    return (i * 32'h9E3779B1) ^ 32'h13572468;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Memory model: acknowledges a pending request after lat cycles
  always @(negedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0;
      waitCnt = 0;
    end else if (memAck) begin
      memAck <= 1'b0;
    end else if (memReq) begin
      if (waitCnt >= lat) begin
        waitCnt = 0;
        chk(memAddr[2:0] == 3'b0, "R9 aligned", 64'(memAddr), 64'(memAddr & ~12'h7));
        if (memWe) begin
          wrCnt++;
          if (wbSeen < expWbN) begin
            chk(memAddr == expWbAddr[wbSeen], "R7 wb addr", 64'(memAddr),
                64'(expWbAddr[wbSeen]));
            chk(memWdata == {refw[memAddr[AW-1:2] + 1], refw[memAddr[AW-1:2]]},
                "R7 wb data", memWdata,
                {refw[memAddr[AW-1:2] + 1], refw[memAddr[AW-1:2]]});
          end else begin
            chk(0, "R8 unexpected write", 64'(memAddr), 64'(0));
          end
          wbSeen++;
          mem[memAddr[AW-1:3]] = memWdata;
        end else begin
          rdCnt++;
          fillSeen = 1;
          chk(wbSeen == expWbN, "R7 wb before fill", 64'(wbSeen), 64'(expWbN));
          chk(memAddr == expFillAddr, "R3 fill addr", 64'(memAddr), 64'(expFillAddr));
          memRdata <= mem[memAddr[AW-1:3]];
        end
        memAck <= 1'b1;
      end else begin
        waitCnt++;
      end
    end
  end

  // One processor access; rdata and wasHit returned
  task automatic access(input bit we, input logic [AW-1:0] addr, input logic [3:0] be,
                        input logic [31:0] wdata, input string lab,
                        output logic [31:0] rdata, output bit wasHit);
    int idx = int'(addr[9:5]);
    int sb  = int'(addr[4:3]);
    logic [1:0] tg = addr[11:10];
    bit hitE = (tagM[idx] == tg) && validM[idx][sb];
    bit mism = (tagM[idx] != tg);
    int guard = 0;
    logic [31:0] w;
    @(negedge clk);
    expWbN = 0;
    if (!hitE && mism && dirtyM[idx]) begin
      for (int s = 0; s < 4; s++) begin
        if (validM[idx][s]) begin
          expWbAddr[expWbN] = {tagM[idx], addr[9:5], 2'(s), 3'b0};
          expWbN++;
        end
      end
    end
    wbSeen = 0; rdCnt = 0; wrCnt = 0; fillSeen = 0;
    expFillAddr = {addr[AW-1:3], 3'b0};
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuBe = be; cpuWdata = wdata;
    #1;
    wasHit = cpuReady;
    chk(cpuReady == hitE, hitE ? "R2 zero-wait hit" : "R9 miss not ready",
        64'(cpuReady), 64'(hitE));
    while (!cpuReady && guard < 200) begin
      @(negedge clk); #1;
      guard++;
      if (cpuReady && !fillSeen)
        chk(0, "R9 ready before fill", 64'(fillSeen), 64'(1));
    end
    rdata = cpuRdata;
    @(posedge clk);
    #1;
    chk(rdCnt == (hitE ? 0 : 1), hitE ? "R2 no fetch" : (mism ? "R4 one fetch" : "R3 one fetch"),
        64'(rdCnt), 64'(hitE ? 0 : 1));
    chk(wrCnt == expWbN, (expWbN != 0) ? "R7 wb count" : "R8 no write",
        64'(wrCnt), 64'(expWbN));
    if (!we)
      chk(rdata == refw[addr[AW-1:2]], lab, 64'(rdata), 64'(refw[addr[AW-1:2]]));
    // update requirement model
    if (!hitE) begin
      if (mism) begin validM[idx] = '0; tagM[idx] = tg; dirtyM[idx] = 0; end
      validM[idx][sb] = 1'b1;
    end
    if (we) begin
      dirtyM[idx] = 1;
      w = refw[addr[AW-1:2]];
      for (int b = 0; b < 4; b++) if (be[b]) w[b*8 +: 8] = wdata[b*8 +: 8];
      refw[addr[AW-1:2]] = w;
    end
  endtask

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    bit h;
    logic [31:0] seed = 32'h2468ACE1;
    for (int i = 0; i < WORDS; i++) refw[i] = initWord(i);
    for (int k = 0; k < SBLKS; k++) mem[k] = {initWord(2*k + 1), initWord(2*k)};
    for (int l = 0; l < 32; l++) begin tagM[l] = '0; validM[l] = '0; dirtyM[l] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk(cpuReady == 1'b0, "R1 ready low after reset", 64'(cpuReady), 64'(0));
    chk(memReq == 1'b0, "R1 no mem request after reset", 64'(memReq), 64'(0));
    rstN = 1'b1;

    // directed corners
    lat = 1;
    access(0, 12'h000, 4'h0, 0, "R1 first read data", rd, h);
    chk(!h, "R1 first access misses", 64'(h), 64'(0));
    access(0, 12'h004, 4'h0, 0, "R10 word select", rd, h);
    chk(h, "R10 same sub-block hits", 64'(h), 64'(1));
    access(0, 12'h008, 4'h0, 0, "R3 sub-block miss data", rd, h);
    chk(!h, "R3 invalid sub-block misses", 64'(h), 64'(0));
    access(0, 12'h000, 4'h0, 0, "R3 retained data", rd, h);
    chk(h, "R3 other sub-block retained", 64'(h), 64'(1));
    access(1, 12'h010, 4'b0101, 32'hDEADBEEF, "", rd, h);
    chk(!h, "R5 write miss", 64'(h), 64'(0));
    access(0, 12'h010, 4'h0, 0, "R5 merged read", rd, h);
    chk(rd == {initWord(4)[31:24], 8'hAD, initWord(4)[15:8], 8'hEF}, "R5 merge bytes",
        64'(rd), 64'({initWord(4)[31:24], 8'hAD, initWord(4)[15:8], 8'hEF}));
    access(1, 12'h000, 4'b1000, 32'hA1B2C3D4, "", rd, h);
    chk(h && wrCnt == 0 && rdCnt == 0, "R6 write hit no traffic", 64'(h), 64'(1));
    access(0, 12'h000, 4'h0, 0, "R6 partial write", rd, h);
    chk(rd == {8'hA1, initWord(0)[23:0]}, "R6 enabled byte only",
        64'(rd), 64'({8'hA1, initWord(0)[23:0]}));
    lat = 0;
    access(0, 12'h400, 4'h0, 0, "R4 new tag data", rd, h);
    chk(wrCnt == 3, "R7 three valid sub-blocks written", 64'(wrCnt), 64'(3));
    access(0, 12'h408, 4'h0, 0, "R4 new tag sibling", rd, h);
    chk(!h, "R4 sibling sub-block invalid", 64'(h), 64'(0));
    lat = 2;
    access(0, 12'h800, 4'h0, 0, "R8 clean replace data", rd, h);
    chk(wrCnt == 0, "R8 clean replace no write", 64'(wrCnt), 64'(0));

    // sweep every word address in order
    for (int i = 0; i < WORDS; i++) begin
      lat = i % 3;
      access(0, AW'(i * 4), 4'h0, 0, "R10 sweep read", rd, h);
    end

    // mixed pseudo-random loads and stores
    for (int n = 0; n < 2500; n++) begin
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      lat = int'(seed[27:26]) % 3;
      access(seed[31], {seed[11:2], 2'b00}, seed[15:12], seed ^ 32'h5A5A0F0F,
             "R2 random read", rd, h);
    end

    @(negedge clk);
    cpuReq = 1'b0;
    repeat (2) @(posedge clk);
    finishRun();
  end

endmodule